// File: doc/BRIEF.md
# Partial and Unaligned Load Data Formatter

This block sits at the end of a load pipeline and turns a naturally aligned memory word into the value written back to the destination register. It receives the load opcode, the two low bits of the effective address, the word fetched from that address with its low bits cleared, the current contents of the destination register and the destination register index. Two cycles later it presents the write-back value, the index and a write strobe.

Byte and halfword loads pick a lane out of the word, with byte 0 in the most significant position, and then sign- or zero-extend it. Word loads and linked word loads pass the word through unchanged. The two unaligned loads shift the word by a whole number of bytes, set by the address low bits, and splice it with the bytes of the old register value that they keep. A write aimed at register 0 is dropped, and so is any opcode that is not a load.

Top module: `lm_load_merge`

## Requirements
- R1: While reset is held, and on the first sampling after it is released, `wb_valid` is 0.
- R2: A request accepted at a rising edge shows its result on `wb_*` right after the second rising edge that follows, and back-to-back requests come out in order, one per cycle.
- R3: Opcode 32 (signed byte) takes byte lane `a` of the word, where lane 0 is bits 31:24 and lane 3 is bits 7:0, and sign-extends it to 32 bits.
- R4: Opcode 36 (unsigned byte) takes the same lane as R3 and zero-extends it, so bits 31:8 of the result are 0.
- R5: Opcode 33 (signed halfword) and opcode 37 (unsigned halfword) take bits 31:16 when address bit 1 is 0 and bits 15:0 when it is 1, and ignore address bit 0. Opcode 33 sign-extends and opcode 37 zero-extends.
- R6: Opcode 35 (word) and opcode 48 (linked word) return the fetched word unchanged for every address low-bit value.
- R7: Opcode 34 (load-left) with low bits `a` returns the word shifted left by 8·a bits, with the low 8·a bits taken from the old register value. For a = 0 it returns the whole word.
- R8: Opcode 38 (load-right) with low bits `a` returns the old register value when a = 0. Otherwise it returns the word shifted right by 8·(4−a) bits, with the high 8·(4−a) bits taken from the old register value.
- R9: A request whose destination index is 0 never raises `wb_valid`.
- R10: A request with any opcode other than 32–38 and 48 never raises `wb_valid`.
- R11: `wb_idx` carries the destination index of the request whose data is on `wb_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A load result is offered this cycle |
| req_opc | input | 6 | Major opcode of the load |
| req_addr_lo | input | 2 | Low two bits of the effective address |
| req_mem | input | 32 | Aligned memory word |
| req_old | input | 32 | Current destination register value |
| req_idx | input | 5 | Destination register index |
| wb_valid | output | 1 | Write-back strobe |
| wb_idx | output | 5 | Write-back register index |
| wb_data | output | 32 | Write-back value |

## Verification
The byte and halfword opcodes are driven at every address low-bit value, using words whose lanes alternate between negative and positive values. This shows whether the lane numbering is big-endian and whether the extension follows the right sign bit. The unaligned pair runs all four offsets against a memory word and an old value that share no byte, so any wrong shift amount or wrong kept mask changes the result. Index 0, opcodes that are not loads and an unbroken stream of mixed requests separate the write squash from the pipeline timing.

// File: rtl/lm_pkg.sv
package lm_pkg;

   localparam int OPC_W = 6;

   localparam logic [OPC_W-1:0] OPC_BYTE_S  = 6'd32;
   localparam logic [OPC_W-1:0] OPC_HALF_S  = 6'd33;
   localparam logic [OPC_W-1:0] OPC_LEFT    = 6'd34;
   localparam logic [OPC_W-1:0] OPC_WORD    = 6'd35;
   localparam logic [OPC_W-1:0] OPC_BYTE_U  = 6'd36;
   localparam logic [OPC_W-1:0] OPC_HALF_U  = 6'd37;
   localparam logic [OPC_W-1:0] OPC_RIGHT   = 6'd38;
   localparam logic [OPC_W-1:0] OPC_LINKED  = 6'd48;

   typedef enum logic [2:0] {
      K_NONE   = 3'd0,
      K_BYTE_S = 3'd1,
      K_BYTE_U = 3'd2,
      K_HALF_S = 3'd3,
      K_HALF_U = 3'd4,
      K_WORD   = 3'd5,
      K_LEFT   = 3'd6,
      K_RIGHT  = 3'd7
   } ld_kind_e;

endpackage

// File: rtl/lm_decode.sv
module lm_decode
   import lm_pkg::*;
(
   input  logic [OPC_W-1:0] opc,
   output ld_kind_e         kind,
   output logic             is_merge
);

   always_comb begin
      unique case (opc)
         OPC_BYTE_S: kind = K_BYTE_S;
         OPC_BYTE_U: kind = K_BYTE_U;
         OPC_HALF_S: kind = K_HALF_S;
         OPC_HALF_U: kind = K_HALF_U;
         OPC_WORD,
         OPC_LINKED: kind = K_WORD;
         OPC_LEFT:   kind = K_LEFT;
         OPC_RIGHT:  kind = K_RIGHT;
         default:    kind = K_NONE;
      endcase
   end

   assign is_merge = (kind == K_LEFT) || (kind == K_RIGHT);

endmodule

// File: rtl/lm_lane_extract.sv
module lm_lane_extract
   import lm_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4
) (
   input  ld_kind_e                     kind,
   input  logic [$clog2(LANES)-1:0]     lane,
   input  logic [BYTE_W*LANES-1:0]      word,
   output logic [BYTE_W*LANES-1:0]      ext
);

   localparam int DW = BYTE_W * LANES;
   localparam int HW = 2 * BYTE_W;
   localparam int HL = LANES / 2;
   localparam int AW = $clog2(LANES);

   logic [BYTE_W-1:0] byte_q [LANES];
   logic [HW-1:0]     half_q [HL];
   logic [BYTE_W-1:0] sel_byte;
   logic [HW-1:0]     sel_half;

   // big-endian numbering: lane 0 is the most significant byte
   for (genvar b = 0; b < LANES; b++) begin : g_byte
      assign byte_q[b] = word[(LANES-1-b)*BYTE_W +: BYTE_W];
   end

   for (genvar h = 0; h < HL; h++) begin : g_half
      assign half_q[h] = word[(HL-1-h)*HW +: HW];
   end

   assign sel_byte = byte_q[lane];
   assign sel_half = half_q[lane[AW-1:1]];

   always_comb begin
      unique case (kind)
         K_BYTE_S: ext = {{(DW-BYTE_W){sel_byte[BYTE_W-1]}}, sel_byte};
         K_BYTE_U: ext = {{(DW-BYTE_W){1'b0}}, sel_byte};
         K_HALF_S: ext = {{(DW-HW){sel_half[HW-1]}}, sel_half};
         K_HALF_U: ext = {{(DW-HW){1'b0}}, sel_half};
         default:  ext = word;
      endcase
   end

endmodule

// File: rtl/lm_unaligned_merge.sv
module lm_unaligned_merge #(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4
) (
   input  logic                         from_right,
   input  logic [$clog2(LANES)-1:0]     shift,
   input  logic [BYTE_W*LANES-1:0]      word,
   input  logic [BYTE_W*LANES-1:0]      old,
   output logic [BYTE_W*LANES-1:0]      merged
);

   localparam int DW = BYTE_W * LANES;

   logic [DW-1:0] left_c  [LANES];
   logic [DW-1:0] right_c [LANES];

   // one candidate per byte offset, then a single mux on the offset
   for (genvar k = 0; k < LANES; k++) begin : g_off
      if (k == 0) begin : g_zero
         assign left_c[k]  = word;
         assign right_c[k] = old;
      end else begin : g_nz
         assign left_c[k]  = {word[DW-1-k*BYTE_W:0], old[k*BYTE_W-1:0]};
         assign right_c[k] = {old[DW-1 -: (LANES-k)*BYTE_W],
                              word[DW-1 -: k*BYTE_W]};
      end
   end

   assign merged = from_right ? right_c[shift] : left_c[shift];

endmodule

// File: rtl/lm_load_merge.sv
module lm_load_merge
   import lm_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4,
   parameter int IDX_W  = 5
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         req_valid,
   input  logic [5:0]                   req_opc,
   input  logic [$clog2(LANES)-1:0]     req_addr_lo,
   input  logic [BYTE_W*LANES-1:0]      req_mem,
   input  logic [BYTE_W*LANES-1:0]      req_old,
   input  logic [IDX_W-1:0]             req_idx,
   output logic                         wb_valid,
   output logic [IDX_W-1:0]             wb_idx,
   output logic [BYTE_W*LANES-1:0]      wb_data
);

   localparam int DW = BYTE_W * LANES;

   if (BYTE_W < 1) begin : g_chk_byte
      $error("lm_load_merge: BYTE_W must be at least 1");
   end
   if (LANES < 4 || (LANES & (LANES - 1)) != 0) begin : g_chk_lanes
      $error("lm_load_merge: LANES must be a power of two, at least 4");
   end
   if (IDX_W < 1) begin : g_chk_idx
      $error("lm_load_merge: IDX_W must be at least 1");
   end

   ld_kind_e       kind;
   logic           is_merge;
   logic [DW-1:0]  ext_d;
   logic [DW-1:0]  mrg_d;

   lm_decode u_dec (
      .opc      (req_opc),
      .kind     (kind),
      .is_merge (is_merge)
   );

   lm_lane_extract #(.BYTE_W(BYTE_W), .LANES(LANES)) u_ext (
      .kind (kind),
      .lane (req_addr_lo),
      .word (req_mem),
      .ext  (ext_d)
   );

   lm_unaligned_merge #(.BYTE_W(BYTE_W), .LANES(LANES)) u_mrg (
      .from_right (kind == K_RIGHT),
      .shift      (req_addr_lo),
      .word       (req_mem),
      .old        (req_old),
      .merged     (mrg_d)
   );

   // stage 1: both formatted candidates registered
   logic           s1_valid;
   logic           s1_merge;
   logic [IDX_W-1:0] s1_idx;
   logic [DW-1:0]  s1_ext;
   logic [DW-1:0]  s1_mrg;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_valid <= 1'b0;
         s1_merge <= 1'b0;
         s1_idx   <= '0;
         s1_ext   <= '0;
         s1_mrg   <= '0;
      end else begin
         s1_valid <= req_valid && (kind != K_NONE);
         s1_merge <= is_merge;
         s1_idx   <= req_idx;
         s1_ext   <= ext_d;
         s1_mrg   <= mrg_d;
      end
   end

   // stage 2: final select and write-back register, index 0 squashed
   always_ff @(posedge clk) begin
      if (rst) begin
         wb_valid <= 1'b0;
         wb_idx   <= '0;
         wb_data  <= '0;
      end else begin
         wb_valid <= s1_valid && (s1_idx != '0);
         wb_idx   <= s1_idx;
         wb_data  <= s1_merge ? s1_mrg : s1_ext;
      end
   end

endmodule

// File: rtl/lm_load_merge_chk.sv
module lm_load_merge_chk #(
   parameter int IDX_W = 5,
   parameter int DW    = 32,
   parameter int AW    = 2
) (
   input logic             clk,
   input logic             rst,
   input logic             req_valid,
   input logic [5:0]       req_opc,
   input logic [AW-1:0]    req_addr_lo,
   input logic [DW-1:0]    req_mem,
   input logic [DW-1:0]    req_old,
   input logic [IDX_W-1:0] req_idx,
   input logic             wb_valid,
   input logic [IDX_W-1:0] wb_idx,
   input logic [DW-1:0]    wb_data
);

   logic is_load;
   logic takes;
   logic p1, p2;

   assign is_load = (req_opc inside {6'd32, 6'd33, 6'd34, 6'd35,
                                     6'd36, 6'd37, 6'd38, 6'd48});
   assign takes   = req_valid && is_load && (req_idx != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         p1 <= 1'b0;
         p2 <= 1'b0;
      end else begin
         p1 <= takes;
         p2 <= p1;
      end
   end

   AST_WB_TIMING: assert property (@(posedge clk) disable iff (rst)
      wb_valid == p2);                                              // R2
   AST_NO_ZERO_IDX: assert property (@(posedge clk) disable iff (rst)
      wb_valid |-> (wb_idx != '0));                                 // R9
   AST_WORD_PASS: assert property (@(posedge clk) disable iff (rst)
      $past(takes && (req_opc == 6'd35 || req_opc == 6'd48), 2)
      |-> wb_data == $past(req_mem, 2));                            // R6
   AST_RIGHT_ZERO_KEEP: assert property (@(posedge clk) disable iff (rst)
      $past(takes && req_opc == 6'd38 && req_addr_lo == '0, 2)
      |-> wb_data == $past(req_old, 2));                            // R8
   AST_UBYTE_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
      $past(takes && req_opc == 6'd36, 2)
      |-> wb_data[DW-1:8] == '0);                                   // R4
   AST_IDX_FOLLOW: assert property (@(posedge clk) disable iff (rst)
      $past(takes, 2) |-> wb_idx == $past(req_idx, 2));             // R11

endmodule

bind lm_load_merge lm_load_merge_chk #(
   .IDX_W (IDX_W),
   .DW    (BYTE_W * LANES),
   .AW    ($clog2(LANES))
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .req_valid   (req_valid),
   .req_opc     (req_opc),
   .req_addr_lo (req_addr_lo),
   .req_mem     (req_mem),
   .req_old     (req_old),
   .req_idx     (req_idx),
   .wb_valid    (wb_valid),
   .wb_idx      (wb_idx),
   .wb_data     (wb_data)
);

// File: tb/tb_lm_load_merge.sv
`timescale 1ns/1ps
module tb_lm_load_merge;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic [5:0]  req_opc = '0;
   logic [1:0]  req_addr_lo = '0;
   logic [31:0] req_mem = '0;
   logic [31:0] req_old = '0;
   logic [4:0]  req_idx = '0;
   logic        wb_valid;
   logic [4:0]  wb_idx;
   logic [31:0] wb_data;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit mon_on = 1'b0;

   always #4 clk = ~clk;   // 125 MHz
   always @(posedge clk) cyc <= cyc + 1;

   lm_load_merge dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_opc(req_opc),
      .req_addr_lo(req_addr_lo), .req_mem(req_mem), .req_old(req_old),
      .req_idx(req_idx), .wb_valid(wb_valid), .wb_idx(wb_idx),
      .wb_data(wb_data)
   );

   typedef struct {
      int          due;
      bit          v;
      logic [31:0] data;
      logic [4:0]  idx;
      string       tag;
   } item_t;

   item_t sb[$];

   function automatic logic [31:0] model(input logic [5:0] opc,
                                         input logic [1:0] a,
                                         input logic [31:0] mem,
                                         input logic [31:0] old,
                                         output bit wr);
      logic [7:0]  m [4];
      logic [7:0]  o [4];
      logic [7:0]  r [4];
      logic [7:0]  b;
      logic [15:0] h;
      int          sh;
      for (int i = 0; i < 4; i++) begin
         m[i] = mem[31-8*i -: 8];
         o[i] = old[31-8*i -: 8];
      end
      wr = 1'b1;
      b  = m[a];
      h  = {m[{a[1], 1'b0}], m[{a[1], 1'b1}]};
      sh = int'(a);
      model = '0;
      case (opc)
         6'd32: model = {{24{b[7]}}, b};
         6'd36: model = {24'h0, b};
         6'd33: model = {{16{h[15]}}, h};
         6'd37: model = {16'h0, h};
         6'd35, 6'd48: model = mem;
         6'd34: begin
            for (int i = 0; i < 4; i++) r[i] = (i < 4 - sh) ? m[i + sh] : o[i];
            model = {r[0], r[1], r[2], r[3]};
         end
         6'd38: begin
            for (int i = 0; i < 4; i++) r[i] = (i < 4 - sh) ? o[i] : m[i - (4 - sh)];
            model = {r[0], r[1], r[2], r[3]};
         end
         default: wr = 1'b0;
      endcase
   endfunction

   task automatic issue(input logic [5:0] opc, input logic [1:0] a,
                        input logic [31:0] mem, input logic [31:0] old,
                        input logic [4:0] idx, input string tag);
      item_t it;
      bit    wr;
      @(negedge clk);
      req_valid   = 1'b1;
      req_opc     = opc;
      req_addr_lo = a;
      req_mem     = mem;
      req_old     = old;
      req_idx     = idx;
      it.due  = cyc + 2;
      it.data = model(opc, a, mem, old, wr);
      it.v    = wr && (idx != 5'd0);
      it.idx  = idx;
      it.tag  = tag;
      sb.push_back(it);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   // monitor: compare the scoreboard head against the write-back port
   initial begin
      forever begin
         @(negedge clk);
         if (mon_on) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
               item_t it;
               it = sb.pop_front();
               checks++;
               if (wb_valid !== it.v ||
                   (it.v && (wb_data !== it.data || wb_idx !== it.idx))) begin
                  fails++;
                  $display("FAIL %s: valid=%0b data=%h idx=%0d expected valid=%0b data=%h idx=%0d",
                           it.tag, wb_valid, wb_data, wb_idx, it.v, it.data, it.idx);
               end
            end else if (wb_valid !== 1'b0) begin
               checks++;
               fails++;
               $display("FAIL R2 stray write: valid=%0b data=%h expected valid=0",
                        wb_valid, wb_data);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   localparam logic [31:0] MIX = 32'h8C_3F_A5_71;
   localparam logic [31:0] OLD = 32'h11_22_33_44;

   initial begin
      repeat (4) @(negedge clk);
      checks++;
      if (wb_valid !== 1'b0) begin
         fails++;
         $display("FAIL R1 during reset: valid=%0b expected 0", wb_valid);
      end
      rst = 1'b0;
      @(negedge clk);
      checks++;
      if (wb_valid !== 1'b0) begin
         fails++;
         $display("FAIL R1 after reset: valid=%0b expected 0", wb_valid);
      end
      mon_on = 1'b1;

      // R3 / R4: every byte lane, mixed signs
      for (int a = 0; a < 4; a++) issue(6'd32, 2'(a), MIX, OLD, 5'd3, "R3 signed byte");
      for (int a = 0; a < 4; a++) issue(6'd36, 2'(a), MIX, OLD, 5'd4, "R4 unsigned byte");
      idle(3);
      // R5: both halves, bit 0 of the address set and clear
      for (int a = 0; a < 4; a++) issue(6'd33, 2'(a), 32'h80F1_7F02, OLD, 5'd5, "R5 signed half");
      for (int a = 0; a < 4; a++) issue(6'd37, 2'(a), 32'h80F1_7F02, OLD, 5'd6, "R5 unsigned half");
      idle(3);
      // R6: word and linked word at every offset
      for (int a = 0; a < 4; a++) issue(6'd35, 2'(a), 32'hDEAD_BEEF, OLD, 5'd7, "R6 word");
      for (int a = 0; a < 4; a++) issue(6'd48, 2'(a), 32'h0BAD_F00D, OLD, 5'd8, "R6 linked");
      idle(3);
      // R7 / R8: unaligned merges, disjoint bytes
      for (int a = 0; a < 4; a++) issue(6'd34, 2'(a), 32'hA1B2_C3D4, OLD, 5'd9, "R7 load-left");
      for (int a = 0; a < 4; a++) issue(6'd38, 2'(a), 32'hA1B2_C3D4, OLD, 5'd10, "R8 load-right");
      idle(3);
      // R9: index 0 dropped for every load type
      issue(6'd35, 2'd0, 32'hFFFF_FFFF, OLD, 5'd0, "R9 word to index 0");
      issue(6'd34, 2'd2, 32'hFFFF_FFFF, OLD, 5'd0, "R9 left to index 0");
      issue(6'd32, 2'd1, 32'hFFFF_FFFF, OLD, 5'd0, "R9 byte to index 0");
      idle(3);
      // R10: opcodes that are not loads
      issue(6'd0,  2'd0, MIX, OLD, 5'd12, "R10 opcode 0");
      issue(6'd39, 2'd1, MIX, OLD, 5'd12, "R10 opcode 39");
      issue(6'd43, 2'd2, MIX, OLD, 5'd12, "R10 opcode 43");
      issue(6'd49, 2'd3, MIX, OLD, 5'd12, "R10 opcode 49");
      idle(3);
      // R2 / R11: unbroken mixed stream with changing indices
      issue(6'd38, 2'd3, 32'h0102_0304, 32'hF0E0_D0C0, 5'd31, "R11 stream right");
      issue(6'd32, 2'd2, 32'h0000_FF00, OLD, 5'd1, "R2 stream byte");
      issue(6'd40, 2'd0, MIX, OLD, 5'd2, "R10 stream non-load");
      issue(6'd34, 2'd1, 32'h0102_0304, 32'hF0E0_D0C0, 5'd17, "R11 stream left");
      issue(6'd37, 2'd3, 32'h1234_8765, OLD, 5'd0, "R9 stream index 0");
      issue(6'd33, 2'd2, 32'h1234_8765, OLD, 5'd30, "R2 stream half");
      idle(6);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule